// File: doc/BRIEF.md
# Eight-Neighbour Tiled Cell Cache

This block is a read cache for a grid map that returns, in one lookup, the records of all eight cells surrounding a chosen centre cell. The map is stored in external memory as square tiles. One cache line holds one tile. The cache is split into four banks. The bank of a tile is picked by the parity of its tile X and tile Y coordinates. Any 3x3 neighbourhood covers at most two tiles per axis, so it never needs two different tiles from the same bank. All eight neighbours are therefore served in parallel without a bank conflict.

A requester presents a centre coordinate with a ready/valid handshake.

- A read request returns the eight neighbour records together.
- A write request stores one record at the centre cell and marks its line dirty.

Neighbours that fall in the same tile share one lookup of that line. When one or more banks miss, the request stalls. The banks are then served one after another. For each bank, a dirty victim is first written back as 64-bit beats and the new tile is then read in. The request completes once every needed line is resident.

Top module: `nbr_cache_top`

## Requirements
- R1: A read request for centre (x,y) returns eight records on `rsp_cells`. Port d occupies bits [d*CELL_W +: CELL_W], and ports 0..7 are the neighbours at offsets (-1,-1), (0,-1), (+1,-1), (-1,0), (+1,0), (-1,+1), (0,+1), (+1,+1). When every needed line is resident, `rsp_valid` rises on the first clock edge after the accepting edge.
- R2: A tile is 2^TB x 2^TB cells. A line is moved as beats at beat address {tileY, tileX, row}. Beat k holds tile row k, and cell column c sits at bits [c*CELL_W +: CELL_W] of its beat.
- R3: A tile maps to bank {tileY[0], tileX[0]}. A centre on a tile corner, whose neighbours span four tiles, is served in one lookup once those tiles are resident.
- R4: Neighbours in the same tile share one lookup. A missing tile costs exactly one refill of 2^(2*TB)*CELL_W/64 read beats, however many ports address it.
- R5: Each bank is 2-way set associative, with set index taken from the low bits of {tileY>>1, tileX>>1}. An invalid way is filled first; otherwise the least recently used way is replaced.
- R6: A write request stores its data at the centre cell and marks the line dirty. Evicting a dirty line writes all its beats to memory before any refill read of that miss. Evicting a clean line issues no write.
- R7: A neighbour outside the map returns the obstacle record, which has only bit CELL_W-1 set, and causes no memory access.
- R8: `req_ready` is low from the cycle after an acceptance until the response. Memory commands occur only while `req_ready` is low. A command not accepted by `mem_cmd_ready` is held unchanged.
- R9: After reset `req_ready` is 1 and both `rsp_valid` and `mem_cmd_valid` are 0. All lines are invalid.
- R10: `rsp_valid` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_x | input | CB | Centre cell X |
| req_y | input | CB | Centre cell Y |
| req_write | input | 1 | 1 = write centre cell, 0 = read neighbours |
| req_wdata | input | CELL_W | Record for a write request |
| rsp_valid | output | 1 | Response pulse |
| rsp_cells | output | 8*CELL_W | Eight neighbour records |
| mem_cmd_valid | output | 1 | Memory beat command present |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_cmd_addr | output | AW | Beat address |
| mem_cmd_wdata | output | 64 | Write beat data |
| mem_rvalid | input | 1 | Read beat returned |
| mem_rdata | input | 64 | Read beat data |

## Verification
The hardest state to reach is a dirty line chosen as the least recently used victim in a full set. Reaching it takes a write to one tile, two more tiles of the same bank and set, and a re-touch that changes the replacement order. A directed sequence on a reduced map with two sets per bank builds this exact history. It then counts write and read beats per request and reads the written cell back after the tile returns from memory. Random requests with a randomly stalling memory then cover mixed reads and writes across many evictions against a bench-side map image.

// File: rtl/nbr_cache_pkg.sv
package nbr_cache_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_LOOK, ST_WBACK, ST_RCMD, ST_RDAT} cst_e;

  // neighbour order: row above left to right, same row, row below
  function automatic int dir_dx(input int d);
    case (d)
      0, 3, 5: dir_dx = -1;
      1, 6:    dir_dx = 0;
      default: dir_dx = 1;
    endcase
  endfunction

  function automatic int dir_dy(input int d);
    case (d)
      0, 1, 2: dir_dy = -1;
      3, 4:    dir_dy = 0;
      default: dir_dy = 1;
    endcase
  endfunction
endpackage

// File: rtl/grid_nbr_route.sv
module grid_nbr_route
  import nbr_cache_pkg::*;
#(
  parameter int CB = 8,
  parameter int TB = 2
) (
  input  logic [CB-1:0]    cx,
  input  logic [CB-1:0]    cy,
  input  logic             is_wr,
  output logic [7:0]       d_in,
  output logic [1:0]       d_bank [8],
  output logic [2*TB-1:0]  d_ofs  [8],
  output logic [3:0]       b_need,
  output logic [CB-TB-1:0] b_tx   [4],
  output logic [CB-TB-1:0] b_ty   [4]
);
  // point 8 is the centre, used only by write requests
  logic [CB:0] px [9];
  logic [CB:0] py [9];
  logic [8:0]  pact;

  always_comb begin
    for (int p = 0; p < 9; p++) begin
      if (p == 8) begin
        px[p] = {1'b0, cx};
        py[p] = {1'b0, cy};
      end else begin
        px[p] = {1'b0, cx} + (CB+1)'(dir_dx(p));
        py[p] = {1'b0, cy} + (CB+1)'(dir_dy(p));
      end
      pact[p] = !px[p][CB] && !py[p][CB] && ((p == 8) == is_wr);
    end
  end

  always_comb begin
    for (int d = 0; d < 8; d++) begin
      d_in[d]   = !px[d][CB] && !py[d][CB];
      d_bank[d] = {py[d][TB], px[d][TB]};
      d_ofs[d]  = {py[d][TB-1:0], px[d][TB-1:0]};
    end
  end

  // merge: each bank takes the tile of the first active point landing in it
  always_comb begin
    for (int b = 0; b < 4; b++) begin
      b_need[b] = 1'b0;
      b_tx[b]   = '0;
      b_ty[b]   = '0;
      for (int p = 0; p < 9; p++) begin
        if (pact[p] && ({py[p][TB], px[p][TB]} == 2'(b)) && !b_need[b]) begin
          b_need[b] = 1'b1;
          b_tx[b]   = px[p][CB-1:TB];
          b_ty[b]   = py[p][CB-1:TB];
        end
      end
    end
  end
endmodule

// File: rtl/nbr_cache_bank.sv
module nbr_cache_bank #(
  parameter int SETS   = 8,
  parameter int TAGW   = 7,
  parameter int LINE_W = 256,
  parameter int BEAT_W = 64,
  parameter int CELL_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(SETS)-1:0]    set_i,
  input  logic [TAGW-1:0]            tag_i,
  input  logic                       touch_en,
  input  logic                       touch_way,
  input  logic                       fill_en,
  input  logic                       fill_last,
  input  logic                       fill_way,
  input  logic [$clog2(LINE_W/BEAT_W)-1:0] fill_beat,
  input  logic [BEAT_W-1:0]          fill_data,
  input  logic                       cwr_en,
  input  logic                       cwr_way,
  input  logic [$clog2(LINE_W/CELL_W)-1:0] cwr_ofs,
  input  logic [CELL_W-1:0]          cwr_data,
  output logic                       hit,
  output logic                       hit_way,
  output logic [LINE_W-1:0]          hit_line,
  output logic                       vic_way,
  output logic                       vic_dirty,
  output logic [TAGW-1:0]            vic_tag,
  output logic [LINE_W-1:0]          vic_line
);
  logic [LINE_W-1:0] line_mem [2][SETS];
  logic [TAGW-1:0]   tag_mem  [2][SETS];
  logic [SETS-1:0]   vld_q   [2];
  logic [SETS-1:0]   dirty_q [2];
  logic [SETS-1:0]   lru_q;          // way to replace next
  logic              h0, h1;

  always_ff @(posedge clk) begin
    if (fill_en)
      line_mem[fill_way][set_i][fill_beat*BEAT_W +: BEAT_W] <= fill_data;
    if (cwr_en)
      line_mem[cwr_way][set_i][cwr_ofs*CELL_W +: CELL_W] <= cwr_data;
    if (fill_en && fill_last)
      tag_mem[fill_way][set_i] <= tag_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q[0]   <= '0;
      vld_q[1]   <= '0;
      dirty_q[0] <= '0;
      dirty_q[1] <= '0;
      lru_q      <= '0;
    end else begin
      if (fill_en && fill_last) begin
        vld_q[fill_way][set_i]   <= 1'b1;
        dirty_q[fill_way][set_i] <= 1'b0;
        lru_q[set_i]             <= !fill_way;
      end
      if (touch_en) lru_q[set_i] <= !touch_way;
      if (cwr_en) dirty_q[cwr_way][set_i] <= 1'b1;
    end
  end

  always_comb begin
    h0        = vld_q[0][set_i] && (tag_mem[0][set_i] == tag_i);
    h1        = vld_q[1][set_i] && (tag_mem[1][set_i] == tag_i);
    hit       = h0 || h1;
    hit_way   = h1;
    hit_line  = line_mem[hit_way][set_i];
    vic_way   = !vld_q[0][set_i] ? 1'b0 : (!vld_q[1][set_i] ? 1'b1 : lru_q[set_i]);
    vic_dirty = vld_q[vic_way][set_i] && dirty_q[vic_way][set_i];
    vic_tag   = tag_mem[vic_way][set_i];
    vic_line  = line_mem[vic_way][set_i];
  end
endmodule

// File: rtl/nbr_cache_top.sv
module nbr_cache_top
  import nbr_cache_pkg::*;
#(
  parameter int CB     = 8,
  parameter int TB     = 2,
  parameter int CELL_W = 16,
  parameter int BEAT_W = 64,
  parameter int SETS   = 8,
  localparam int AW    = 2*(CB-TB) + $clog2(((1 << (2*TB))*CELL_W)/BEAT_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [CB-1:0]         req_x,
  input  logic [CB-1:0]         req_y,
  input  logic                  req_write,
  input  logic [CELL_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [8*CELL_W-1:0]   rsp_cells,
  output logic                  mem_cmd_valid,
  input  logic                  mem_cmd_ready,
  output logic                  mem_cmd_write,
  output logic [AW-1:0]         mem_cmd_addr,
  output logic [BEAT_W-1:0]     mem_cmd_wdata,
  input  logic                  mem_rvalid,
  input  logic [BEAT_W-1:0]     mem_rdata
);
  localparam int TCB    = CB - TB;
  localparam int KB     = 2*(TCB-1);
  localparam int SB     = $clog2(SETS);
  localparam int TAGW   = KB - SB;
  localparam int CELLS  = 1 << (2*TB);
  localparam int LINE_W = CELLS*CELL_W;
  localparam int BEATS  = LINE_W/BEAT_W;
  localparam int BTB    = $clog2(BEATS);
  localparam logic [CELL_W-1:0] OOB = {1'b1, {(CELL_W-1){1'b0}}};

  cst_e              st_q;
  logic [CB-1:0]     x_q, y_q;
  logic              wr_q;
  logic [CELL_W-1:0] wd_q;
  logic [1:0]        cur_q, fm;
  logic              way_q;
  logic [BTB-1:0]    beat_q;
  logic              rsp_valid_q;
  logic [8*CELL_W-1:0] rsp_q, rsp_next;

  logic [7:0]        d_in;
  logic [1:0]        d_bank [8];
  logic [2*TB-1:0]   d_ofs  [8];
  logic [3:0]        b_need, miss;
  logic [TCB-1:0]    b_tx [4];
  logic [TCB-1:0]    b_ty [4];
  logic [KB-1:0]     key_b [4];

  logic [3:0]        hit_v, hway_v, vway_v, vdirty_v;
  logic [LINE_W-1:0] hline [4];
  logic [LINE_W-1:0] vline [4];
  logic [TAGW-1:0]   vtag  [4];
  logic [1:0]        cbank;
  logic              look_done, last_beat;
  logic [KB-1:0]     vkey;

  grid_nbr_route #(.CB(CB), .TB(TB)) u_route (
    .cx(x_q), .cy(y_q), .is_wr(wr_q),
    .d_in(d_in), .d_bank(d_bank), .d_ofs(d_ofs),
    .b_need(b_need), .b_tx(b_tx), .b_ty(b_ty)
  );

  assign cbank     = {y_q[TB], x_q[TB]};
  assign miss      = b_need & ~hit_v;
  assign look_done = (st_q == ST_LOOK) && (miss == '0);
  assign last_beat = (beat_q == BTB'(BEATS-1));

  for (genvar b = 0; b < 4; b++) begin : g_bank
    assign key_b[b] = {b_ty[b][TCB-1:1], b_tx[b][TCB-1:1]};
    nbr_cache_bank #(
      .SETS(SETS), .TAGW(TAGW), .LINE_W(LINE_W), .BEAT_W(BEAT_W), .CELL_W(CELL_W)
    ) u_bank (
      .clk(clk), .rst(rst),
      .set_i(key_b[b][SB-1:0]), .tag_i(key_b[b][KB-1:SB]),
      .touch_en(look_done && b_need[b]), .touch_way(hway_v[b]),
      .fill_en((st_q == ST_RDAT) && mem_rvalid && (cur_q == 2'(b))),
      .fill_last(last_beat), .fill_way(way_q), .fill_beat(beat_q), .fill_data(mem_rdata),
      .cwr_en(look_done && wr_q && (cbank == 2'(b))), .cwr_way(hway_v[b]),
      .cwr_ofs({y_q[TB-1:0], x_q[TB-1:0]}), .cwr_data(wd_q),
      .hit(hit_v[b]), .hit_way(hway_v[b]), .hit_line(hline[b]),
      .vic_way(vway_v[b]), .vic_dirty(vdirty_v[b]), .vic_tag(vtag[b]), .vic_line(vline[b])
    );
  end

  // lowest-numbered missing bank is served first
  always_comb begin
    fm = 2'd0;
    for (int b = 3; b >= 0; b--) if (miss[b]) fm = 2'(b);
  end

  always_comb begin
    for (int d = 0; d < 8; d++)
      rsp_next[d*CELL_W +: CELL_W] = d_in[d] ? hline[d_bank[d]][d_ofs[d]*CELL_W +: CELL_W] : OOB;
  end

  assign vkey          = {vtag[cur_q], key_b[cur_q][SB-1:0]};
  assign mem_cmd_valid = (st_q == ST_WBACK) || (st_q == ST_RCMD);
  assign mem_cmd_write = (st_q == ST_WBACK);
  assign mem_cmd_wdata = vline[cur_q][beat_q*BEAT_W +: BEAT_W];
  assign mem_cmd_addr  = (st_q == ST_WBACK)
                       ? {vkey[KB-1:TCB-1], cur_q[1], vkey[TCB-2:0], cur_q[0], beat_q}
                       : {b_ty[cur_q], b_tx[cur_q], beat_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; rsp_valid_q <= 1'b0; rsp_q <= '0;
      x_q <= '0; y_q <= '0; wr_q <= 1'b0; wd_q <= '0;
      cur_q <= '0; way_q <= 1'b0; beat_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          x_q <= req_x; y_q <= req_y; wr_q <= req_write; wd_q <= req_wdata;
          st_q <= ST_LOOK;
        end
        ST_LOOK: if (miss == '0) begin
          rsp_valid_q <= 1'b1;
          if (!wr_q) rsp_q <= rsp_next;
          st_q <= ST_IDLE;
        end else begin
          cur_q  <= fm;
          way_q  <= vway_v[fm];
          beat_q <= '0;
          st_q   <= vdirty_v[fm] ? ST_WBACK : ST_RCMD;
        end
        ST_WBACK: if (mem_cmd_ready) begin
          beat_q <= last_beat ? '0 : beat_q + 1'b1;
          if (last_beat) st_q <= ST_RCMD;
        end
        ST_RCMD: if (mem_cmd_ready) st_q <= ST_RDAT;
        ST_RDAT: if (mem_rvalid) begin
          beat_q <= last_beat ? '0 : beat_q + 1'b1;
          st_q   <= last_beat ? ST_LOOK : ST_RCMD;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_cells = rsp_q;
endmodule

// File: rtl/nbr_cache_chk.sv
module nbr_cache_chk #(
  parameter int CB     = 8,
  parameter int CELL_W = 16,
  parameter int AW     = 14
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic [CB-1:0]       req_x,
  input logic [CB-1:0]       req_y,
  input logic                req_write,
  input logic                rsp_valid,
  input logic [8*CELL_W-1:0] rsp_cells,
  input logic                mem_cmd_valid,
  input logic                mem_cmd_ready,
  input logic                mem_cmd_write,
  input logic [AW-1:0]       mem_cmd_addr
);
  localparam logic [CELL_W-1:0] OOB = {1'b1, {(CELL_W-1){1'b0}}};
  logic [CB-1:0] acc_x, acc_y;
  logic          acc_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_x <= '1; acc_y <= '1; acc_wr <= 1'b1;
    end else if (req_valid && req_ready) begin
      acc_x <= req_x; acc_y <= req_y; acc_wr <= req_write;
    end
  end

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  a_r8_cmd_held: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_write)));
  a_r8_mem_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_cmd_valid |-> !req_ready);
  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  a_r7_oob_west: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !acc_wr && (acc_x == '0)) |->
      (rsp_cells[0*CELL_W +: CELL_W] == OOB && rsp_cells[3*CELL_W +: CELL_W] == OOB &&
       rsp_cells[5*CELL_W +: CELL_W] == OOB));
  a_r7_oob_north: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !acc_wr && (acc_y == '0)) |->
      (rsp_cells[0*CELL_W +: CELL_W] == OOB && rsp_cells[1*CELL_W +: CELL_W] == OOB &&
       rsp_cells[2*CELL_W +: CELL_W] == OOB));
endmodule

bind nbr_cache_top nbr_cache_chk #(.CB(CB), .CELL_W(CELL_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_x(req_x), .req_y(req_y), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_cells(rsp_cells),
  .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
  .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr)
);

// File: tb/tb_nbr_cache_top.sv
`timescale 1ns/100ps
module tb_nbr_cache_top;
  localparam int CB = 5, TB = 2, CELL_W = 16, BEAT_W = 64, SETS = 2;
  localparam int N = 32, AW = 8, BEATS = 4;
  localparam logic [15:0] OOB = 16'h8000;

  logic clk, rst, req_valid, req_ready, req_write, rsp_valid;
  logic [CB-1:0] req_x, req_y;
  logic [15:0] req_wdata;
  logic [127:0] rsp_cells;
  logic mem_cmd_valid, mem_cmd_ready, mem_cmd_write, mem_rvalid;
  logic [AW-1:0] mem_cmd_addr;
  logic [63:0] mem_cmd_wdata, mem_rdata;

  nbr_cache_top #(.CB(CB), .TB(TB), .CELL_W(CELL_W), .BEAT_W(BEAT_W), .SETS(SETS)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_y(req_y), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_cells(rsp_cells),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
    .mem_cmd_wdata(mem_cmd_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  logic [15:0] gold [N*N];
  logic [63:0] mem  [256];
  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;
  bit cmd_seen = 0, first_we = 0, done = 0;
  int lat;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int ddx(input int d);
    if (d == 0 || d == 3 || d == 5) return -1;
    if (d == 1 || d == 6) return 0;
    return 1;
  endfunction
  function automatic int ddy(input int d);
    if (d < 3) return -1;
    if (d < 5) return 0;
    return 1;
  endfunction

  function automatic logic [127:0] expect_nbrs(input int x, input int y);
    logic [127:0] v;
    for (int d = 0; d < 8; d++) begin
      int nx = x + ddx(d);
      int ny = y + ddy(d);
      if (nx < 0 || ny < 0 || nx >= N || ny >= N) v[d*16 +: 16] = OOB;
      else v[d*16 +: 16] = gold[ny*N + nx];
    end
    return v;
  endfunction

  // memory model: beat {ty,tx,row}, column c at bits c*16
  initial begin
    mem_cmd_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(posedge clk);
      mem_rvalid <= 1'b0;
      if (!rst && mem_cmd_valid && mem_cmd_ready) begin
        if (mem_cmd_write) begin
          mem[mem_cmd_addr] = mem_cmd_wdata;
          if (!cmd_seen) first_we = 1;
          n_wr++;
        end else begin
          mem_rdata  <= mem[mem_cmd_addr];
          mem_rvalid <= 1'b1;
          n_rd++;
        end
        cmd_seen = 1;
      end
      mem_cmd_ready <= ($urandom % 4) != 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  task automatic do_req(input int x, input int y, input bit w, input logic [15:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n_rd = 0; n_wr = 0; cmd_seen = 0; first_we = 0;
    req_x = CB'(x); req_y = CB'(y); req_write = w; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 ready low after accept", {127'd0, req_ready}, 128'd0);
    lat = 0;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    if (!w) check("R1/R2 neighbour data", rsp_cells, expect_nbrs(x, y));
    else gold[y*N + x] = wd;
    @(negedge clk);
    check("R10 response pulse", {127'd0, rsp_valid}, 128'd0);
  endtask

  task automatic reset_dut();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset outputs", {125'd0, req_ready, rsp_valid, mem_cmd_valid}, {125'd0, 3'b100});
  endtask

  initial begin
    void'($urandom(32'd1777));
    req_valid = 0; req_write = 0; req_x = '0; req_y = '0; req_wdata = '0; rst = 1'b1;
    for (int y = 0; y < N; y++)
      for (int x = 0; x < N; x++) begin
        gold[y*N + x] = 16'((x*37 + y*101 + 5) & 16'h7fff);
        mem[{y[4:2], x[4:2], y[1:0]}][x[1:0]*16 +: 16] = gold[y*N + x];
      end
    reset_dut();

    // R4: interior centre, one tile
    do_req(5, 5, 0, 0);
    check("R4 one refill for merged tile", {64'(n_rd), 64'(n_wr)}, {64'(BEATS), 64'd0});
    do_req(5, 5, 0, 0);
    check("R1 hit latency", {64'(lat), 64'(n_rd)}, {64'd1, 64'd0});
    // R3: tile corner, four banks
    do_req(8, 8, 0, 0);
    check("R3 three new tiles", 128'(n_rd), 128'(3*BEATS));
    do_req(8, 8, 0, 0);
    check("R3 corner single lookup", {64'(lat), 64'(n_rd)}, {64'd1, 64'd0});
    // R7: map edges
    do_req(0, 0, 0, 0);
    check("R7 only in-map tile fetched", 128'(n_rd), 128'(BEATS));
    do_req(31, 31, 0, 0);
    check("R7 far corner in-map tile only", 128'(n_rd), 128'(BEATS));

    // R5/R6: bank 0, set 0 tiles A(0,0) B(0,2) C(4,0) D(4,2)
    reset_dut();
    do_req(1, 1, 1, 16'h1234);
    check("R6 write miss refill only", {64'(n_rd), 64'(n_wr)}, {64'(BEATS), 64'd0});
    do_req(1, 9, 0, 0);
    do_req(2, 2, 0, 0);
    check("R6 written cell visible", {64'(lat), 48'd0, rsp_cells[15:0]}, {64'd1, 48'd0, 16'h1234});
    do_req(17, 1, 0, 0);
    check("R5 LRU evicts clean B", {64'(n_rd), 64'(n_wr)}, {64'(BEATS), 64'd0});
    do_req(2, 2, 0, 0);
    check("R5 recently used A kept", {64'(lat), 64'(n_rd)}, {64'd1, 64'd0});
    do_req(1, 9, 0, 0);
    check("R5 B refilled over C", {64'(n_rd), 64'(n_wr)}, {64'(BEATS), 64'd0});
    do_req(17, 9, 0, 0);
    check("R6 dirty A written back first", {64'(n_wr), 63'd0, first_we}, {64'(BEATS), 64'd1});
    check("R6 refill after writeback", 128'(n_rd), 128'(BEATS));
    do_req(2, 2, 0, 0);
    check("R6 data survives round trip", {112'd0, rsp_cells[15:0]}, {112'd0, 16'h1234});

    // random mix
    for (int i = 0; i < 400; i++) begin
      int x = $urandom % N;
      int y = $urandom % N;
      bit w = ($urandom % 4) == 0;
      do_req(x, y, w, 16'($urandom));
    end
    finish_run();
  end
endmodule